// File: doc/BRIEF.md
# Quadword SECDED Corrector with Byte-Parity Regeneration

This block takes one 72-bit code word read from main storage and repairs it before it is handed on. The word holds 64 data bits and 8 check bits. Any single flipped bit is corrected, and that includes a flipped check bit. Two flipped bits are detected but left as they are. The repaired quadword leaves the block as four 16-bit words, one per clock. Each word carries a freshly computed odd parity bit for each of its two bytes, so the downstream store gets byte parity instead of the storage check bits.

A client pulses `start_i` while `busy_o` is low and presents the code word on `code_i` in that same clock. The pipeline spends three clocks on the syndrome, the decision and the correction. It then emits the four words in consecutive clocks, most significant word first. Two status flags travel with every word of the quadword: one for a corrected error and one for an uncorrectable error. On an uncorrectable error, every emitted byte carries wrong (even) parity, so any later parity checker rejects the data.

Top module: `qw_secded_corrector`

## Requirements
- R1: Code word layout. `code_i[63:0]` holds the data and `code_i[70:64]` holds Hamming check bits h0..h6. `code_i[71]` is an overall bit that makes the number of ones in all 72 bits even. Each data bit is given a position from 3 to 71, in ascending order, that is not a power of two: data bit 0 gets 3, bit 1 gets 5, and so on. Check bit hj sits at position 2^j and equals the XOR of the data bits whose position has bit j set.
- R2: When the 7-bit syndrome (the XOR of the positions of all set bits) is zero and the overall parity of the 72 bits is even, the data comes out unchanged and both flags are clear.
- R3: When the overall parity is odd and the syndrome names a data position, that data bit is inverted on output, `sec_o` is 1 and `ded_o` is 0.
- R4: When the overall parity is odd and the syndrome is zero or a power of two, the error is in a check bit or the overall bit. The data is unchanged and `sec_o` is 1.
- R5: When the overall parity is even and the syndrome is nonzero, `ded_o` is 1, `sec_o` is 0 and the data is passed on uncorrected.
- R6: When the overall parity is odd and the syndrome is above 71, the error cannot be a single-bit error. It is reported with `ded_o` set, `sec_o` clear and the data uncorrected.
- R7: If `start_i` is accepted at clock edge E0, `word_valid_o` is high after edges E3, E4, E5 and E6 and low after E7, unless a new start follows. That is exactly four words, with the last one visible seven edges after the start.
- R8: The words are emitted in order data[63:48], data[47:32], data[31:16], data[15:0].
- R9: `par_o[1]` belongs to `word_o[15:8]` and `par_o[0]` belongs to `word_o[7:0]`. Without a double error, each byte together with its parity bit has an odd number of ones.
- R10: With `ded_o` set, each byte together with its parity bit has an even number of ones.
- R11: `sec_o` and `ded_o` hold the same values on all four words of a quadword and are zero when `word_valid_o` is low.
- R12: `busy_o` is high from the clock after an accepted start until the last word is on the output. A `start_i` seen while `busy_o` is high is ignored and does not change the words being produced.
- R13: After reset, `word_valid_o`, `busy_o`, `sec_o` and `ded_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe, accepted when busy_o is low |
| code_i | input | 72 | Code word: data, Hamming check bits, overall bit |
| busy_o | output | 1 | Quadword in flight; starts ignored |
| word_valid_o | output | 1 | word_o, par_o and the flags are valid |
| word_o | output | 16 | Corrected data word |
| par_o | output | 2 | Regenerated byte parity (bit 1 for the upper byte) |
| sec_o | output | 1 | Single error corrected in this quadword |
| ded_o | output | 1 | Uncorrectable error in this quadword |

## Verification
Clean code words with zero, all-ones and mixed data confirm pass-through, the word order and the parity. These cases differ from the error cases only in their flags. Single flips are placed on data bits in each of the four output words and on a Hamming check bit and the overall bit. Together these separate true correction from passing the data through with the flag set. Two kinds of double flips (data plus data, data plus check) and a triple flip whose syndrome lands above position 71 test the uncorrectable path and the forced bad parity. Back-to-back quadwords and starts applied while busy test the seven-edge timing and show that a start during a burst is ignored.

// File: rtl/qw_secded_pkg.sv
package qw_secded_pkg;

    localparam int QW_DATA_W  = 64;
    localparam int QW_WORD_W  = 16;
    localparam int QW_BYTE_W  = 8;
    localparam int QW_HAM_W   = 7;
    localparam int QW_WORDS   = QW_DATA_W / QW_WORD_W;
    localparam int QW_NBYTES  = QW_WORD_W / QW_BYTE_W;
    localparam int QW_CODE_W  = QW_DATA_W + QW_HAM_W + 1;
    localparam int QW_LAST_POS = QW_DATA_W + QW_HAM_W;
    localparam int QW_WIDX_W  = $clog2(QW_WORDS);
    localparam int QW_PH_W    = $clog2(QW_WORDS + 4);

    localparam logic [QW_PH_W-1:0] PH_IDLE = QW_PH_W'(0);
    localparam logic [QW_PH_W-1:0] PH_CAP  = QW_PH_W'(1);
    localparam logic [QW_PH_W-1:0] PH_SYN  = QW_PH_W'(2);
    localparam logic [QW_PH_W-1:0] PH_FIX  = QW_PH_W'(3);
    localparam logic [QW_PH_W-1:0] PH_LAST = QW_PH_W'(3 + QW_WORDS);

    typedef struct packed {
        logic [QW_PH_W-1:0]   phase;
        logic [QW_CODE_W-1:0] cw;
        logic [QW_HAM_W-1:0]  syn;
        logic                 ovp;
        logic [QW_DATA_W-1:0] data;
        logic                 sec;
        logic                 ded;
        logic                 vld;
        logic [QW_WORD_W-1:0] word;
        logic [QW_NBYTES-1:0] par;
    } qw_state_t;

    // Position of data bit idx in the Hamming layout: skip powers of two.
    function automatic logic [QW_HAM_W-1:0] qw_data_pos(input int idx);
        int cnt;
        logic [QW_HAM_W-1:0] r;
        cnt = 0;
        r   = '0;
        for (int p = 3; p <= QW_LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) r = p[QW_HAM_W-1:0];
                cnt++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/qw_syndrome.sv
module qw_syndrome
    import qw_secded_pkg::*;
(
    input  logic [QW_CODE_W-1:0] cw_i,
    output logic [QW_HAM_W-1:0]  syn_o,
    output logic                 ovp_o
);
    always_comb begin
        syn_o = '0;
        for (int i = 0; i < QW_DATA_W; i++) begin
            if (cw_i[i]) syn_o = syn_o ^ qw_data_pos(i);
        end
        for (int j = 0; j < QW_HAM_W; j++) begin
            syn_o[j] = syn_o[j] ^ cw_i[QW_DATA_W + j];
        end
        ovp_o = ^cw_i;
    end
endmodule

// File: rtl/qw_fix.sv
module qw_fix
    import qw_secded_pkg::*;
(
    input  logic [QW_DATA_W-1:0] data_i,
    input  logic [QW_HAM_W-1:0]  syn_i,
    input  logic                 ovp_i,
    output logic [QW_DATA_W-1:0] data_o,
    output logic                 sec_o,
    output logic                 ded_o
);
    always_comb begin
        data_o = data_i;
        sec_o  = 1'b0;
        ded_o  = 1'b0;
        if (ovp_i) begin
            if (int'(syn_i) > QW_LAST_POS) begin
                ded_o = 1'b1;
            end else begin
                sec_o = 1'b1;
                for (int i = 0; i < QW_DATA_W; i++) begin
                    if (syn_i == qw_data_pos(i)) data_o[i] = ~data_i[i];
                end
            end
        end else if (syn_i != '0) begin
            ded_o = 1'b1;
        end
    end
endmodule

// File: rtl/qw_bytepar.sv
module qw_bytepar #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = WORD_W / BYTE_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              bad_i,
    output logic [NB-1:0]     par_o
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign par_o[b] = ~(^word_i[b*BYTE_W +: BYTE_W]) ^ bad_i;
    end
endmodule

// File: rtl/qw_secded_corrector.sv
module qw_secded_corrector
    import qw_secded_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [QW_CODE_W-1:0] code_i,
    output logic                 busy_o,
    output logic                 word_valid_o,
    output logic [QW_WORD_W-1:0] word_o,
    output logic [QW_NBYTES-1:0] par_o,
    output logic                 sec_o,
    output logic                 ded_o
);
    qw_state_t st_d, st_q;

    logic [QW_HAM_W-1:0]  syn_w;
    logic                 ovp_w;
    logic [QW_DATA_W-1:0] fixed_w;
    logic                 sec_w, ded_w;
    logic [QW_PH_W-1:0]   ph_off;
    logic [QW_WIDX_W-1:0] widx;
    logic [QW_DATA_W-1:0] shifted;
    logic [QW_WORD_W-1:0] sel_word;
    logic [QW_NBYTES-1:0] par_w;

    qw_syndrome u_syn (
        .cw_i  (st_q.cw),
        .syn_o (syn_w),
        .ovp_o (ovp_w)
    );

    qw_fix u_fix (
        .data_i (st_q.cw[QW_DATA_W-1:0]),
        .syn_i  (st_q.syn),
        .ovp_i  (st_q.ovp),
        .data_o (fixed_w),
        .sec_o  (sec_w),
        .ded_o  (ded_w)
    );

    // Word index 0 selects the most significant word.
    assign ph_off   = st_q.phase - PH_FIX;
    assign widx     = ph_off[QW_WIDX_W-1:0];
    assign shifted  = st_q.data >> (QW_WORD_W * (QW_WORDS - 1 - int'(widx)));
    assign sel_word = shifted[QW_WORD_W-1:0];

    qw_bytepar #(
        .WORD_W (QW_WORD_W),
        .BYTE_W (QW_BYTE_W)
    ) u_par (
        .word_i (sel_word),
        .bad_i  (st_q.ded),
        .par_o  (par_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.phase == PH_IDLE || st_q.phase == PH_LAST) begin
            st_d.phase = PH_IDLE;
            if (start_i) begin
                st_d.cw    = code_i;
                st_d.phase = PH_CAP;
            end
        end else if (st_q.phase == PH_CAP) begin
            st_d.syn   = syn_w;
            st_d.ovp   = ovp_w;
            st_d.phase = PH_SYN;
        end else if (st_q.phase == PH_SYN) begin
            st_d.data  = fixed_w;
            st_d.sec   = sec_w;
            st_d.ded   = ded_w;
            st_d.phase = PH_FIX;
        end else begin
            st_d.word  = sel_word;
            st_d.par   = par_w;
            st_d.vld   = 1'b1;
            st_d.phase = st_q.phase + QW_PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o       = (st_q.phase != PH_IDLE) && (st_q.phase != PH_LAST);
    assign word_valid_o = st_q.vld;
    assign word_o       = st_q.word;
    assign par_o        = st_q.par;
    assign sec_o        = st_q.vld & st_q.sec;
    assign ded_o        = st_q.vld & st_q.ded;
endmodule

// File: rtl/qw_secded_chk.sv
module qw_secded_chk
    import qw_secded_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 busy_o,
    input logic                 word_valid_o,
    input logic [QW_WORD_W-1:0] word_o,
    input logic [QW_NBYTES-1:0] par_o,
    input logic                 sec_o,
    input logic                 ded_o
);
    logic odd_all, even_all;
    logic [2:0] run_q;

    always_comb begin
        odd_all  = 1'b1;
        even_all = 1'b1;
        for (int b = 0; b < QW_NBYTES; b++) begin
            if (!(^{word_o[b*QW_BYTE_W +: QW_BYTE_W], par_o[b]})) odd_all  = 1'b0;
            if ( (^{word_o[b*QW_BYTE_W +: QW_BYTE_W], par_o[b]})) even_all = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (word_valid_o) run_q <= run_q + 3'd1;
        else                   run_q <= '0;
    end

    // R9
    odd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o && !ded_o |-> odd_all);

    // R10
    bad_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o && ded_o |-> even_all);

    // R5
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_o && ded_o));

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o && $past(word_valid_o) && (run_q != 3'd0) |-> $stable(sec_o) && $stable(ded_o));

    // R12
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_valid_o) |-> run_q == 3'(QW_WORDS));

    // R7
    burst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> run_q < 3'(QW_WORDS));
endmodule

bind qw_secded_corrector qw_secded_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .word_valid_o (word_valid_o),
    .word_o       (word_o),
    .par_o        (par_o),
    .sec_o        (sec_o),
    .ded_o        (ded_o)
);

// File: tb/qw_secded_corrector_tb.sv
module qw_secded_corrector_tb;
    import qw_secded_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [QW_CODE_W-1:0] code_i = '0;
    logic                 busy_o, word_valid_o, sec_o, ded_o;
    logic [QW_WORD_W-1:0] word_o;
    logic [QW_NBYTES-1:0] par_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    typedef struct {
        logic [15:0] w;
        logic [1:0]  p;
        logic        sec;
        logic        ded;
        int          at;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qw_secded_corrector u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .code_i       (code_i),
        .busy_o       (busy_o),
        .word_valid_o (word_valid_o),
        .word_o       (word_o),
        .par_o        (par_o),
        .sec_o        (sec_o),
        .ded_o        (ded_o)
    );

    // R1 layout: n-th position >= 3 that is not a power of two.
    function automatic int pos_of(input int i);
        int p = 2;
        int n = -1;
        while (n < i) begin
            p++;
            if ((p & (p - 1)) != 0) n++;
        end
        return p;
    endfunction

    function automatic int idx_of_pos(input int p);
        for (int i = 0; i < 64; i++) if (pos_of(i) == p) return i;
        return -1;
    endfunction

    function automatic logic [71:0] enc(input logic [63:0] d);
        logic [71:0] c;
        c = '0;
        c[63:0] = d;
        for (int j = 0; j < 7; j++) begin
            for (int i = 0; i < 64; i++) if (((pos_of(i) >> j) & 1) == 1) c[64 + j] ^= d[i];
        end
        c[71] = ^c[70:0];
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: wait for a free slot, queue the expected words, pulse start.
    task automatic send(input logic [71:0] code, input logic [63:0] exp_d,
                        input logic es, input logic ed, input string req);
        int s;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        s = cyc;
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            logic [15:0] w;
            w = exp_d[63 - 16*k -: 16];
            e.w   = w;
            e.p   = ed ? {^w[15:8], ^w[7:0]} : {~^w[15:8], ~^w[7:0]};
            e.sec = es;
            e.ded = ed;
            e.at  = s + 4 + k;
            e.req = req;
            sb.push_back(e);
        end
        start_i = 1'b1;
        code_i  = code;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Monitor: compare each emitted word with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && word_valid_o) begin
            if (sb.size() == 0) begin
                check("R7 unexpected word", 32'(word_o), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, "/R8 word"}, 32'(word_o), 32'(e.w));
                check({e.req, "/R9/R10 parity"}, 32'(par_o), 32'(e.p));
                check({e.req, "/R11 flags"}, {30'd0, sec_o, ded_o}, {30'd0, e.sec, e.ded});
                check({e.req, "/R7 timing"}, 32'(cyc), 32'(e.at));
            end
        end
        if (rst_n && !word_valid_o) begin
            if (sec_o || ded_o) check("R11 flags idle", {30'd0, sec_o, ded_o}, 32'd0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [71:0] c;
        int a, b, t;

        repeat (3) @(negedge clk);
        check("R13 valid", 32'(word_valid_o), 32'd0);
        check("R13 busy",  32'(busy_o), 32'd0);
        check("R13 flags", {30'd0, sec_o, ded_o}, 32'd0);
        rst_n = 1'b1;

        // R2 clean words
        send(enc(64'h0), 64'h0, 1'b0, 1'b0, "R2");
        send(enc('1), '1, 1'b0, 1'b0, "R2");
        d = 64'h0123_4567_89AB_CDEF;
        send(enc(d), d, 1'b0, 1'b0, "R2");

        // R3 single data-bit flips in every output word
        foreach (t_bits[i]) begin
            d = 64'hA5C3_0F96_3C5A_E718;
            c = enc(d);
            c[t_bits[i]] = ~c[t_bits[i]];
            send(c, d, 1'b1, 1'b0, "R3");
        end

        // R4 check-bit and overall-bit flips
        d = 64'h1357_9BDF_2468_ACE0;
        c = enc(d); c[67] = ~c[67];
        send(c, d, 1'b1, 1'b0, "R4");
        c = enc(d); c[71] = ~c[71];
        send(c, d, 1'b1, 1'b0, "R4");

        // R5 double flips: data+data, data+check
        d = 64'hDEAD_BEEF_0BAD_F00D;
        c = enc(d); c[5] = ~c[5]; c[30] = ~c[30];
        send(c, c[63:0], 1'b0, 1'b1, "R5");
        c = enc(d); c[50] = ~c[50]; c[65] = ~c[65];
        send(c, c[63:0], 1'b0, 1'b1, "R5");

        // R6 triple flip at positions 67,5,9 -> syndrome 79
        d = 64'h0F0F_F0F0_3333_CCCC;
        a = idx_of_pos(67); b = idx_of_pos(5); t = idx_of_pos(9);
        c = enc(d); c[a] = ~c[a]; c[b] = ~c[b]; c[t] = ~c[t];
        send(c, c[63:0], 1'b0, 1'b1, "R6");

        // R12 start while busy is ignored
        d = 64'h8421_1248_7E7E_8181;
        send(enc(d), d, 1'b0, 1'b0, "R12");
        check("R12 busy", 32'(busy_o), 32'd1);
        start_i = 1'b1;
        code_i  = enc(64'hFFFF_0000_FFFF_0000) ^ 72'h3;
        @(negedge clk);
        check("R12 busy", 32'(busy_o), 32'd1);
        @(negedge clk);
        start_i = 1'b0;
        send(enc(64'h0000_0000_0000_0001), 64'h1, 1'b0, 1'b0, "R12");

        @(negedge clk);
        while (busy_o || sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R7 drained", 32'(sb.size()), 32'd0);
        check("R12 no extra burst", 32'(word_valid_o), 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    int t_bits[4] = '{0, 17, 40, 63};
endmodule